// File: doc/BRIEF.md
# Serial Memory Slave with Write-Busy Polling

This block is the two-wire serial slave front end of a small byte-addressed memory. It oversamples SCL and SDA on the system clock, finds start and stop conditions, and matches a 7-bit device address. A write transaction carries one address byte and then any number of data bytes. A read transaction streams bytes out from an internal address counter. That counter keeps its value from one transaction to the next, which gives current-address, random and sequential reads.

When a stop ends a transaction that wrote at least one data byte, the block models a nonvolatile programming cycle. A busy timer runs for a fixed number of system clocks. While it runs, the block does not acknowledge its device address. A master can therefore send start plus address again and again until it gets an acknowledge. A transaction that only sets the address does not start the timer, so a random read can set the address first without a wait.

The memory sits outside the block behind a synchronous port. A read request returns its data in the following cycle. The block pulls SDA low only through an open-drain enable.

Top module: `i2c_mem_slave`

## Requirements
- R1: A byte received after a start is acknowledged only when its upper seven bits equal DEV_ADDR and no write cycle is running. Any other byte gets no acknowledge, and the block then ignores the bus until the next start.
- R2: When bit 0 of the device byte is 0 (write), the next byte loads the address counter. Each byte after that is written to memory at the counter and acknowledged, and the counter then increments.
- R3: A stop after one or more data bytes have been written makes busy_o rise in the next cycle. It stays high for exactly WR_CYCLES system clocks.
- R4: While busy_o is high, a device byte with either value of bit 0 gets no acknowledge. After busy_o falls, the same byte is acknowledged.
- R5: A write transaction that carries only the address byte leaves busy_o low after its stop.
- R6: When bit 0 of the device byte is 1 (read), the first byte returned comes from the counter address, and the counter then increments. A read with no address phase therefore returns the byte after the last one accessed, across transactions.
- R7: An address-only write followed by a repeated start and a read returns the byte at the address just written.
- R8: An acknowledge from the master (SDA low) in the ninth clock of a read byte makes the block send the next byte, with the address wrapping modulo 2^ADDR_W. SDA high in that ninth clock makes the block release SDA and send nothing more.
- R9: Read data is shifted out most significant bit first, one bit per SCL clock.
- R10: sda_oe_o changes only while SCL is low.
- R11: A memory write never happens while busy_o is high, and never in the same cycle as a memory read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When high, pull SDA low |
| mem_re_o | output | 1 | Memory read request; data valid on the next cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to make a start or a stop. It never ends a transaction while the slave is pulling SDA low. It holds each SCL level for several system clocks, longer than the synchronizer delay. The bench master keeps every SCL phase at five system clocks and moves SDA only inside a low phase. It issues stops and repeated starts only after an ack clock has ended and the slave has let go of the line. The busy-length checks assume each programming cycle runs to its end before the next one can start, and that follows from the address being refused while busy_o is high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } slv_st_e;

  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] ACK_CLK  = 4'd9;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA edge while SCL is held high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         WR_CYCLES   = 5000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o
);
  logic scl_w, sda_w, rise_w, fall_w, start_w, stop_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_w), .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  logic wr_pend_q;

  i2c_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(stop_w & wr_pend_q), .busy_o
  );

  slv_st_e           st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic [ADDR_W-1:0] ctr_q;
  logic              oe_q, rd_q, mack_q, fetch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      tx_q        <= '0;
      ctr_q       <= '0;
      oe_q        <= 1'b0;
      rd_q        <= 1'b0;
      mack_q      <= 1'b0;
      fetch_q     <= 1'b0;
      wr_pend_q   <= 1'b0;
      mem_re_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_re_o <= 1'b0;
      mem_we_o <= 1'b0;
      fetch_q  <= mem_re_o;
      if (fetch_q) tx_q <= mem_rdata_i;

      if (start_w) begin
        st_q  <= ST_DEV;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_w) begin
        st_q      <= ST_IDLE;
        oe_q      <= 1'b0;
        wr_pend_q <= 1'b0;
      end else if (rise_w) begin
        case (st_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (cnt_q < BIT_LAST) begin
              sh_q  <= {sh_q[6:0], sda_w};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RDATA: begin
            if (cnt_q < BIT_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q == BIT_LAST) begin
              // master response in ninth clock
              cnt_q  <= ACK_CLK;
              mack_q <= ~sda_w;
              if (!sda_w) begin
                mem_re_o   <= 1'b1;
                mem_addr_o <= ctr_q;
                ctr_q      <= ctr_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (fall_w) begin
        case (st_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (cnt_q == BIT_LAST) begin
              cnt_q <= ACK_CLK;
              if (st_q == ST_DEV) begin
                if (sh_q[7:1] == DEV_ADDR && !busy_o) begin
                  oe_q <= 1'b1;
                  rd_q <= sh_q[0];
                  if (sh_q[0]) begin
                    mem_re_o   <= 1'b1;
                    mem_addr_o <= ctr_q;
                    ctr_q      <= ctr_q + 1'b1;
                  end
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_ADDR) begin
                oe_q  <= 1'b1;
                ctr_q <= ADDR_W'(sh_q);
              end else begin
                oe_q        <= 1'b1;
                mem_we_o    <= 1'b1;
                mem_addr_o  <= ctr_q;
                mem_wdata_o <= sh_q;
                ctr_q       <= ctr_q + 1'b1;
                wr_pend_q   <= 1'b1;
              end
            end else if (cnt_q == ACK_CLK) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              if (st_q == ST_DEV && rd_q) begin
                st_q <= ST_RDATA;
                oe_q <= ~tx_q[7];
              end else if (st_q == ST_DEV) begin
                st_q <= ST_ADDR;
              end else begin
                st_q <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (cnt_q < BIT_LAST) begin
              oe_q <= ~tx_q[3'd7 - cnt_q[2:0]];
            end else if (cnt_q == BIT_LAST) begin
              oe_q <= 1'b0;
            end else if (mack_q) begin
              cnt_q <= '0;
              oe_q  <= ~tx_q[7];
            end else begin
              st_q <= ST_IDLE;
              oe_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_o,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic stop_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r10_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r4_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  a_r11_no_we_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !busy_o);

  a_r11_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r3_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  a_r3_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 32'(WR_CYCLES));

  a_r3_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 32'(WR_CYCLES));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .stop_i(stop_w)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int WR_CYC = 1000;
  localparam int Q      = 5;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_re, mem_we, busy;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_bus;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave #(.DEV_ADDR(7'h50), .ADDR_W(8), .WR_CYCLES(WR_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy)
  );

  logic [7:0] mdl [256];
  logic [7:0] ref_m [256];
  int checks = 0, errors = 0, wr_cnt = 0, run = 0, last_run = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (mem_we) begin mdl[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_re) mem_rdata <= mdl[mem_addr];
  end

  always @(negedge clk) begin
    if (busy) run = run + 1;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       rd_evt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(rd_evt) begin
    if (exp_q.size() == 0) chk(1'b0, "R8 unexpected byte", int'(got), 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      chk(got === e, t, int'(got), int'(e));
    end
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq(); endtask
  task automatic i2c_stop(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); endtask
  task automatic put_bit(input logic b); sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq(); endtask
  task automatic get_bit(output logic b); sda_m = 1; hq(); scl_m = 1; hq(); b = sda_bus; hq(); scl_m = 0; hq(); endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  // driver: push expected byte, then clock it out
  task automatic rd_byte(input logic [7:0] e, input string tag, input bit mack);
    logic b;
    logic [7:0] v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~mack);
    got = v;
    ->rd_evt;
  endtask

  task automatic wr_seq(input logic [7:0] a, input logic [7:0] d[$]);
    bit ack;
    i2c_start();
    send_byte(DEV_W, ack); chk(ack, "R1 dev ack", ack, 1);
    send_byte(a, ack);     chk(ack, "R2 addr ack", ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(ack, "R2 data ack", ack, 1);
      ref_m[8'(a + i)] = d[i];
    end
    i2c_stop();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_addr(input logic [7:0] a);
    bit ack;
    i2c_start();
    send_byte(DEV_W, ack); chk(ack, "R7 dev ack", ack, 1);
    send_byte(a, ack);     chk(ack, "R7 addr ack", ack, 1);
  endtask

  initial begin
    bit ack;
    int w0;
    for (int i = 0; i < 256; i++) begin mdl[i] = 8'(i * 7) ^ 8'hA5; ref_m[i] = 8'(i * 7) ^ 8'hA5; end
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 0 && busy == 0 && mem_we == 0, "R1 reset state", {sda_oe, busy, mem_we}, 0);

    // R1: wrong device address
    w0 = wr_cnt;
    i2c_start();
    send_byte(8'h42, ack); chk(!ack, "R1 mismatch nack", ack, 0);
    send_byte(8'h77, ack); chk(!ack, "R1 ignored after nack", ack, 0);
    i2c_stop();
    chk(wr_cnt == w0, "R1 no write", wr_cnt, w0);

    // R2/R3: write three bytes
    wr_seq(8'h10, '{8'h11, 8'h22, 8'h33});
    repeat (2) @(negedge clk);
    chk(busy == 1, "R3 busy after stop", busy, 1);

    // R4: polling while busy
    i2c_start(); send_byte(DEV_W, ack); chk(!ack, "R4 write poll nack", ack, 0); i2c_stop();
    i2c_start(); send_byte(DEV_R, ack); chk(!ack, "R4 read poll nack", ack, 0); i2c_stop();
    wait_idle();
    chk(last_run == WR_CYC, "R3 busy length", last_run, WR_CYC);

    // R4/R6: poll succeeds, current address read
    i2c_start(); send_byte(DEV_R, ack); chk(ack, "R4 poll ack", ack, 1);
    rd_byte(ref_m[8'h13], "R6 current read", 1'b0);
    chk(sda_oe == 0, "R8 release after nack", sda_oe, 0);
    i2c_stop();

    // R7/R8/R5: random then sequential read
    set_addr(8'h11);
    i2c_start(); send_byte(DEV_R, ack); chk(ack, "R7 read ack", ack, 1);
    rd_byte(ref_m[8'h11], "R7 random read", 1'b1);
    rd_byte(ref_m[8'h12], "R8 seq read 1", 1'b1);
    rd_byte(ref_m[8'h13], "R8 seq read 2", 1'b0);
    i2c_stop();
    repeat (5) @(negedge clk);
    chk(busy == 0, "R5 no busy after address-only", busy, 0);

    // R6: counter carries over
    i2c_start(); send_byte(DEV_R, ack);
    rd_byte(ref_m[8'h14], "R6 carry over", 1'b0);
    i2c_stop();

    // R8: wrap
    set_addr(8'hFE);
    i2c_start(); send_byte(DEV_R, ack);
    rd_byte(ref_m[8'hFE], "R8 wrap a", 1'b1);
    rd_byte(ref_m[8'hFF], "R8 wrap b", 1'b1);
    rd_byte(ref_m[8'h00], "R8 wrap c", 1'b0);
    i2c_stop();

    // R9: bit order
    wr_seq(8'h40, '{8'h01});
    wait_idle();
    set_addr(8'h40);
    i2c_start(); send_byte(DEV_R, ack);
    rd_byte(8'h01, "R9 msb first", 1'b0);
    i2c_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule